// File: doc/BRIEF.md
# Shared Bus Resolver

This block stands in for a bus that several sources would share through three-state drivers, in logic that has no internal high-impedance state. Each of N sources presents a W-bit word together with one drive-enable bit that covers the whole word. The block counts the asserted enables. It then produces the word the bus would carry, plus two flags. One flag says that nothing drives the bus. The other says that more than one source drives it.

With exactly one enable asserted, the output is that source's word. When the bus has no driver, the output reads as all ones, which is how an undriven line reads once three-state logic is replaced by gates. When two or more sources drive the bus, the true value is unknown, so the output is also forced to all ones. This keeps later logic deterministic. A parameter selects between a purely combinational result and a variant that registers the word and both flags on the rising clock edge, with a synchronous reset.

Top module: `shared_bus_resolver`

## Requirements
- R1: With exactly one enable asserted, `bus_q` equals that source's data word.
- R2: With no enable asserted, `idle` is 1, `conflict` is 0 and `bus_q` is all ones.
- R3: With two or more enables asserted, `conflict` is 1, `idle` is 0 and `bus_q` is all ones.
- R4: With exactly one enable asserted, `idle` and `conflict` are both 0.
- R5: Enable bit i selects the data slice `drv_data[i*W +: W]`, so source 0 occupies the least significant W bits.
- R6: With REGISTERED=1, `bus_q`, `idle` and `conflict` show the result for the inputs present at the previous rising clock edge.
- R7: With REGISTERED=1, a rising edge with `rst` high sets `idle` and `conflict` to 0 and `bus_q` to all ones. With REGISTERED=0, `rst` has no effect on the outputs.
- R8: `idle` and `conflict` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registered variant |
| rst | input | 1 | Synchronous active-high reset (registered variant) |
| drv_en | input | N | One drive-enable bit per source |
| drv_data | input | N*W | Source words, source i at bits [i*W +: W] |
| bus_q | output | W | Resolved bus word |
| idle | output | 1 | No source is driving |
| conflict | output | 1 | More than one source is driving |

## Verification
The bench walks a single enable across every source, and each source carries a distinct word. A design that mis-indexes the slices, or swaps source order, would therefore return a neighbour's word. It applies the all-clear pattern, where a design that forgot the pull-high default would output zeros. It applies random multi-driver patterns, including every enable at once, where a design that counted only to one, or that ORed the words together, would miss the conflict or leak data. A registered instance is compared one edge late, and it is also checked during reset. This exposes a missing pipeline stage or reset values that leave a flag set.

// File: rtl/shared_bus_resolver.sv
module shared_bus_resolver #(
  parameter int N = 4,
  parameter int W = 8,
  parameter bit REGISTERED = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] drv_en,
  input  logic [N*W-1:0] drv_data,
  output logic [W-1:0] bus_q,
  output logic         idle,
  output logic         conflict
);

  localparam int CW = (N < 2) ? 2 : $clog2(N + 1);

  logic [CW-1:0] n_on;
  logic [W-1:0]  merged;
  logic [W-1:0]  word_c;
  logic          idle_c;
  logic          conf_c;

  always_comb begin
    n_on   = '0;
    merged = '0;
    for (int i = 0; i < N; i++) begin
      n_on   = n_on + CW'(drv_en[i]);
      merged = merged | (drv_data[i*W +: W] & {W{drv_en[i]}});
    end
  end

  assign idle_c = (n_on == '0);
  assign conf_c = (n_on > CW'(1));
  assign word_c = (idle_c || conf_c) ? '1 : merged;

  generate
    if (REGISTERED) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          bus_q    <= '1;
          idle     <= 1'b0;
          conflict <= 1'b0;
        end else begin
          bus_q    <= word_c;
          idle     <= idle_c;
          conflict <= conf_c;
        end
      end

      // R6
      reg_idle_lat_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones(drv_en) == 0) |=> (idle && bus_q == '1));
      // R6
      reg_conf_lat_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones(drv_en) > 1) |=> (conflict && bus_q == '1));
      // R7
      reg_reset_chk: assert property (@(posedge clk)
        rst |=> (!idle && !conflict && bus_q == '1));
    end else begin : g_comb
      assign bus_q    = word_c;
      assign idle     = idle_c;
      assign conflict = conf_c;

      // R4
      single_flags_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones(drv_en) == 1) |-> (!idle && !conflict));
      // R2
      none_idle_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones(drv_en) == 0) |-> (idle && bus_q == '1));
    end
  endgenerate

  // R8
  flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(idle && conflict));
  // R3
  conflict_ones_chk: assert property (@(posedge clk) disable iff (rst)
    conflict |-> (bus_q == '1));

endmodule

// File: tb/shared_bus_resolver_tb.sv
module shared_bus_resolver_tb_top;
  localparam int N = 4;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0]   en = '0;
  logic [N*W-1:0] data = '0;
  logic [W-1:0] bq_c, bq_r;
  logic idle_c, idle_r, conf_c, conf_r;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  shared_bus_resolver #(.N(N), .W(W), .REGISTERED(1'b1)) dut_i (
    .clk(clk), .rst(rst), .drv_en(en), .drv_data(data),
    .bus_q(bq_r), .idle(idle_r), .conflict(conf_r));

  shared_bus_resolver #(.N(N), .W(W), .REGISTERED(1'b0)) dut_c (
    .clk(clk), .rst(rst), .drv_en(en), .drv_data(data),
    .bus_q(bq_c), .idle(idle_c), .conflict(conf_c));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model(input logic [N-1:0] e, input logic [N*W-1:0] d,
                       output int word, output int idl, output int cf, output int cnt);
    cnt = 0;
    word = (1 << W) - 1;
    for (int i = 0; i < N; i++) if (e[i]) begin
      cnt++;
      word = int'(d[i*W +: W]);
    end
    if (cnt != 1) word = (1 << W) - 1;
    idl = (cnt == 0);
    cf  = (cnt > 1);
  endtask

  task automatic step(input logic [N-1:0] e, input logic [N*W-1:0] d);
    int w, i0, c0, n;
    string tag;
    @(negedge clk);
    en = e;
    data = d;
    #1;
    model(e, d, w, i0, c0, n);
    tag = (n == 1) ? "R1/R5" : (n == 0) ? "R2" : "R3";
    chk(tag, "comb bus", int'(bq_c), w);
    chk((n == 1) ? "R4" : tag, "comb idle", int'(idle_c), i0);
    chk((n == 1) ? "R4" : tag, "comb conflict", int'(conf_c), c0);
    chk("R8", "comb flag pair", int'(idle_c & conf_c), 0);
    @(posedge clk);
    #1;
    chk("R6", "reg bus", int'(bq_r), w);
    chk("R6", "reg idle", int'(idle_r), i0);
    chk("R6", "reg conflict", int'(conf_r), c0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [N*W-1:0] pat;
    logic [N-1:0] e;
    for (int i = 0; i < N; i++) pat[i*W +: W] = W'(8'h11 * (i + 1) + 8'h20);
    // R7: reset with active inputs
    en = 4'b0010;
    data = pat;
    @(posedge clk);
    #1;
    chk("R7", "reset bus", int'(bq_r), (1 << W) - 1);
    chk("R7", "reset idle", int'(idle_r), 0);
    chk("R7", "reset conflict", int'(conf_r), 0);
    chk("R7", "comb ignores rst", int'(bq_c), int'(pat[W +: W]));
    @(negedge clk);
    rst = 1'b0;
    // R1/R5: every one-hot pattern
    for (int i = 0; i < N; i++) step(N'(1) << i, pat);
    for (int i = N - 1; i >= 0; i--) step(N'(1) << i, ~pat);
    // R2: no driver
    step('0, pat);
    step('0, '0);
    // R3: several drivers
    step('1, pat);
    for (int k = 0; k < 40; k++) begin
      do e = N'($urandom); while ($countones(e) < 2);
      step(e, {$urandom, $urandom});
    end
    for (int k = 0; k < 40; k++) step(N'($urandom), {$urandom, $urandom});
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule